// File: doc/BRIEF.md
# Dual-Rate Ethernet Transmit Media Interface

The block turns a byte-wide packet stream into the transmit side of a media interface. The interface runs in one of two widths, chosen by a mode input. In the 8-bit gigabit width one byte leaves on every clock. In the 4-bit 10/100 width each byte leaves as two nibbles, and the upper four data lines stay low. The block drives the transmit data lines and a transmit enable, both from registers clocked by the transmit clock. The data lines read zero whenever the enable is low.

The collision and carrier-sense inputs can arrive asynchronously, so each one passes through a two-flop synchronizer. In full duplex the collision input serves as hardware flow control. It holds back the start of a new frame, but a frame that has already begun runs to its end. In half duplex the block waits while carrier sense or collision is high. A collision during a frame cuts the frame off: the enable drops, a one-cycle abort pulse is raised, and the rest of that frame is taken from the stream and thrown away. A stream bubble in the middle of a frame is treated the same way. Width and duplex are sampled when a frame starts, so a change made during a frame applies from the next frame.

Top module: `dual_rate_tx_if`

## Requirements
- R1: With gig_mode_i high at frame start, tx_en_o rises on the clock edge that accepts the first byte. txd_o then carries one accepted byte per cycle in order, with bit 0 as the LSB, and tx_en_o stays high for exactly as many cycles as the frame has bytes.
- R2: With gig_mode_i low at frame start, each byte is sent as its low nibble and then its high nibble on txd_o[3:0], with txd_o[7:4] held at zero. tx_en_o stays high for twice the byte count, and successive bytes of a frame are accepted exactly two cycles apart.
- R3: txd_o is zero whenever tx_en_o is low. After reset, tx_en_o, txd_o, abort_o and, with no valid byte, tx_ready_o are all low.
- R4: In full duplex, a synchronized high on col_i stops a new frame from starting. A high on col_i raised during a frame does not shorten it and raises no abort.
- R5: col_i and crs_i act only after two synchronizing register stages. A collision set up before one clock edge is seen by the control logic after the second edge, and tx_en_o drops on the third edge.
- R6: In half duplex, a synchronized high on crs_i or col_i stops a new frame from starting, and the frame starts once both are low.
- R7: In half duplex, a synchronized collision during a frame drops tx_en_o and pulses abort_o high for exactly one cycle, in the same cycle. The remaining bytes of that frame up to and including its last byte are accepted and discarded, and the next frame goes out complete.
- R8: gig_mode_i and half_duplex_i are sampled only when a frame starts. A change during a frame leaves that frame's width and length on the wire unchanged and applies from the next frame.
- R9: If tx_valid_i is low when the next byte of a frame is due, the frame is aborted as in R7: tx_en_o drops, abort_o pulses, and the rest of the frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gig_mode_i | input | 1 | 1: 8-bit gigabit width, 0: 4-bit 10/100 width |
| half_duplex_i | input | 1 | 1: half duplex, 0: full duplex |
| tx_data_i | input | 8 | Stream byte |
| tx_valid_i | input | 1 | Stream byte valid |
| tx_last_i | input | 1 | Marks the last byte of a frame |
| tx_ready_o | output | 1 | Byte accepted on this edge when valid is high |
| col_i | input | 1 | Collision, or flow-control stop in full duplex; asynchronous |
| crs_i | input | 1 | Carrier sense; asynchronous |
| txd_o | output | 8 | Transmit data lines |
| tx_en_o | output | 1 | Transmit enable |
| abort_o | output | 1 | One-cycle pulse when a frame is cut short |

## Verification
The assertions take the stream to keep tx_valid_i high from the first byte to the last byte of a frame. The one exception is the deliberate bubble used to test R9. They also take col_i and crs_i to be held for several clocks, so the synchronized values follow the inputs. The bench drives all inputs on the falling edge and holds collision and carrier sense for many cycles. It changes the mode inputs only while the block is idle, except in the R8 case, which changes them on purpose during a frame to exercise the deferral.

// File: rtl/tx_if_pkg.sv
package tx_if_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DROP = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_if_sync.sv
module tx_if_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/tx_if_ctrl.sv
module tx_if_ctrl
  import tx_if_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gig_mode_i,
  input  logic half_duplex_i,
  input  logic valid_i,
  input  logic last_i,
  input  logic col_s_i,
  input  logic crs_s_i,
  output logic ready_o,
  output logic load_o,
  output logic adv_o,
  output logic stop_o,
  output logic abort_o,
  output logic cfg_gig_o
);
  tx_state_e state_q, state_d;
  logic last_q, phase_q, cfg_gig_q, cfg_half_q, abort_q;
  logic abort_d, go, byte_end, coll;

  // start gate: flow control in full duplex, deferral in half duplex
  assign go       = valid_i && !col_s_i && !(half_duplex_i && crs_s_i);
  assign byte_end = cfg_gig_q || phase_q;
  assign coll     = cfg_half_q && col_s_i;

  always_comb begin
    state_d = state_q;
    ready_o = 1'b0;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    stop_o  = 1'b0;
    abort_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = go;
        if (go) begin
          load_o  = 1'b1;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (coll) begin
          stop_o  = 1'b1;
          abort_d = 1'b1;
          state_d = last_q ? ST_IDLE : ST_DROP;
        end else if (!byte_end) begin
          adv_o = 1'b1;
        end else if (last_q) begin
          stop_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ready_o = 1'b1;
          if (valid_i) begin
            load_o = 1'b1;
          end else begin
            stop_o  = 1'b1;
            abort_d = 1'b1;
            state_d = ST_DROP;
          end
        end
      end
      ST_DROP: begin
        ready_o = 1'b1;
        if (valid_i && last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      last_q     <= 1'b0;
      phase_q    <= 1'b0;
      cfg_gig_q  <= 1'b0;
      cfg_half_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
      if (load_o) begin
        last_q  <= last_i;
        phase_q <= 1'b0;
      end else if (adv_o) begin
        phase_q <= 1'b1;
      end
      if (state_q == ST_IDLE && go) begin
        cfg_gig_q  <= gig_mode_i;
        cfg_half_q <= half_duplex_i;
      end
    end
  end

  assign abort_o   = abort_q;
  assign cfg_gig_o = cfg_gig_q;
endmodule

// File: rtl/tx_if_fmt.sv
module tx_if_fmt #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              stop_i,
  input  logic              gig_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] txd_o,
  output logic              tx_en_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] byte_q;
  logic              en_q, hi_q;
  logic [HALF_W-1:0] nib;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      en_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else if (stop_i) begin
      byte_q <= '0;
      en_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else if (load_i) begin
      byte_q <= data_i;
      en_q   <= 1'b1;
      hi_q   <= 1'b0;
    end else if (adv_i) begin
      hi_q   <= 1'b1;
    end
  end

  assign nib = hi_q ? byte_q[DATA_W-1:HALF_W] : byte_q[HALF_W-1:0];

  always_comb begin
    if (!en_q)      txd_o = '0;
    else if (gig_i) txd_o = byte_q;
    else            txd_o = {{(DATA_W-HALF_W){1'b0}}, nib};
  end

  assign tx_en_o = en_q;
endmodule

// File: rtl/dual_rate_tx_if.sv
module dual_rate_tx_if #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_mode_i,
  input  logic              half_duplex_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  input  logic              col_i,
  input  logic              crs_i,
  output logic [DATA_W-1:0] txd_o,
  output logic              tx_en_o,
  output logic              abort_o
);
  logic [1:0] sync_out;
  logic       col_sync, crs_sync;
  logic       load, adv, stop, cfg_gig;

  tx_if_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({crs_i, col_i}),
    .sync_o (sync_out)
  );
  assign col_sync = sync_out[0];
  assign crs_sync = sync_out[1];

  tx_if_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gig_mode_i   (gig_mode_i),
    .half_duplex_i(half_duplex_i),
    .valid_i      (tx_valid_i),
    .last_i       (tx_last_i),
    .col_s_i      (col_sync),
    .crs_s_i      (crs_sync),
    .ready_o      (tx_ready_o),
    .load_o       (load),
    .adv_o        (adv),
    .stop_o       (stop),
    .abort_o      (abort_o),
    .cfg_gig_o    (cfg_gig)
  );

  tx_if_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .stop_i (stop),
    .gig_i  (cfg_gig),
    .data_i (tx_data_i),
    .txd_o  (txd_o),
    .tx_en_o(tx_en_o)
  );
endmodule

// File: rtl/tx_if_chk.sv
module tx_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_o,
  input logic [DATA_W-1:0] txd_o,
  input logic              abort_o,
  input logic              tx_ready_o,
  input logic              tx_valid_i,
  input logic              half_duplex_i,
  input logic              col_s,
  input logic              crs_s,
  input logic              cfg_gig
);
  localparam int HALF_W = DATA_W / 2;

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !cfg_gig) |-> (txd_o[DATA_W-1:HALF_W] == '0));

  a_r2_nibble_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && tx_valid_i && tx_en_o && !cfg_gig) |=> !tx_ready_o);

  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> (txd_o == '0));

  a_r4_no_start_on_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> !$past(col_s));

  a_r6_no_start_on_crs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_en_o) && $past(half_duplex_i)) |-> !$past(crs_s));

  a_r7_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  a_r7_abort_en_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !tx_en_o);
endmodule

bind dual_rate_tx_if tx_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_o      (tx_en_o),
  .txd_o        (txd_o),
  .abort_o      (abort_o),
  .tx_ready_o   (tx_ready_o),
  .tx_valid_i   (tx_valid_i),
  .half_duplex_i(half_duplex_i),
  .col_s        (col_sync),
  .crs_s        (crs_sync),
  .cfg_gig      (cfg_gig)
);

// File: tb/tb_dual_rate_tx_if.sv
`timescale 1ns/1ps
module tb_dual_rate_tx_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gig = 1'b1, half = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0, last = 1'b0;
  logic       col = 1'b0, crs = 1'b0;
  logic [7:0] txd;
  logic       en, rdy, abort;

  always #10 clk = ~clk;

  dual_rate_tx_if dut (
    .clk_i(clk), .rst_ni(rst_n), .gig_mode_i(gig), .half_duplex_i(half),
    .tx_data_i(data), .tx_valid_i(valid), .tx_last_i(last), .tx_ready_o(rdy),
    .col_i(col), .crs_i(crs), .txd_o(txd), .tx_en_o(en), .abort_o(abort)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx_n = 0, en_cyc = 0, nib_err = 0, idle_err = 0, abort_n = 0;
  logic [7:0] rx [64];
  int acc_t [64];
  logic [3:0] lo = '0;
  logic half_sel = 1'b0, mon_gig = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (en) begin
        en_cyc++;
        if (mon_gig) begin
          rx[rx_n] = txd; rx_n++;
        end else begin
          if (txd[7:4] != 4'h0) nib_err++;
          if (!half_sel) lo = txd[3:0];
          else begin rx[rx_n] = {txd[3:0], lo}; rx_n++; end
          half_sel = ~half_sel;
        end
      end else begin
        if (txd != 8'h00) idle_err++;
        half_sel = 1'b0;
      end
      if (abort) abort_n++;
    end
  end

  function automatic logic [7:0] exp_byte(input int base, input int i);
    return 8'((base + i * 53) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    rx_n = 0; en_cyc = 0; nib_err = 0; idle_err = 0; abort_n = 0;
  endtask

  task automatic push(input int len, input int base, input int gap_at);
    for (int i = 0; i < len; i++) begin
      bit r;
      if (i == gap_at) begin
        @(negedge clk); valid = 1'b0; last = 1'b0;
        repeat (4) @(negedge clk);
      end
      r = 1'b0;
      while (!r) begin
        @(negedge clk);
        data = exp_byte(base, i); valid = 1'b1; last = (i == len - 1);
        #2 r = rdy;
        @(posedge clk);
      end
      acc_t[i] = cyc;
    end
    @(negedge clk); valid = 1'b0; last = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_en();
    while (!en) @(negedge clk);
  endtask

  task automatic cmp_frame(input int len, input int base, input string req);
    int mism = 0;
    for (int i = 0; i < len; i++) if (rx[i] !== exp_byte(base, i)) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk(en == 1'b0, "R3 reset en", int'(en), 0);
    chk(txd == 8'h00, "R3 reset txd", int'(txd), 0);
    chk(abort == 1'b0, "R3 reset abort", int'(abort), 0);
    chk(rdy == 1'b0, "R3 reset ready", int'(rdy), 0);

    // R1 / R2 sweep over widths and lengths
    for (int g = 1; g >= 0; g--) begin
      for (int len = 1; len <= 8; len++) begin
        int base = len * 17 + g * 5;
        int bad = 0;
        gig = g[0]; mon_gig = g[0]; half = 1'b0;
        clr();
        push(len, base, -1);
        settle();
        if (g == 1) begin
          chk(rx_n == len, "R1 length", rx_n, len);
          chk(en_cyc == len, "R1 enable cycles", en_cyc, len);
          cmp_frame(len, base, "R1 data");
          for (int i = 1; i < len; i++) if (acc_t[i] - acc_t[i-1] != 1) bad++;
          chk(bad == 0, "R1 accept spacing", bad, 0);
        end else begin
          chk(rx_n == len, "R2 length", rx_n, len);
          chk(en_cyc == 2 * len, "R2 enable cycles", en_cyc, 2 * len);
          cmp_frame(len, base, "R2 nibble order");
          chk(nib_err == 0, "R2 upper lines", nib_err, 0);
          for (int i = 1; i < len; i++) if (acc_t[i] - acc_t[i-1] != 2) bad++;
          chk(bad == 0, "R2 accept spacing", bad, 0);
        end
        chk(idle_err == 0, "R3 idle data", idle_err, 0);
        chk(abort_n == 0, "R1 no abort", abort_n, 0);
      end
    end

    // R4 full duplex flow control blocks start
    gig = 1'b1; mon_gig = 1'b1; half = 1'b0;
    clr();
    @(negedge clk); col = 1'b1;
    repeat (3) @(negedge clk);
    fork
      push(4, 90, -1);
      begin
        repeat (12) @(negedge clk);
        chk(en_cyc == 0, "R4 start held", en_cyc, 0);
        col = 1'b0;
      end
    join
    settle();
    chk(rx_n == 4, "R4 frame after release", rx_n, 4);
    cmp_frame(4, 90, "R4 data");

    // R4 flow control raised mid-frame does not cut the frame
    gig = 1'b0; mon_gig = 1'b0;
    clr();
    fork
      push(8, 33, -1);
      begin wait_en(); col = 1'b1; end
    join
    settle();
    col = 1'b0;
    chk(rx_n == 8, "R4 frame completes", rx_n, 8);
    chk(abort_n == 0, "R4 no abort", abort_n, 0);
    settle();

    // R6 half duplex carrier sense defers
    gig = 1'b1; mon_gig = 1'b1; half = 1'b1;
    clr();
    @(negedge clk); crs = 1'b1;
    repeat (3) @(negedge clk);
    fork
      push(5, 11, -1);
      begin
        repeat (10) @(negedge clk);
        chk(en_cyc == 0, "R6 deferred", en_cyc, 0);
        crs = 1'b0;
      end
    join
    settle();
    chk(rx_n == 5, "R6 sent after idle", rx_n, 5);
    cmp_frame(5, 11, "R6 data");

    // R5 / R7 half duplex collision mid-frame
    clr();
    fork
      push(20, 77, -1);
      begin
        wait_en();
        repeat (3) @(negedge clk);
        col = 1'b1;
        @(negedge clk);
        chk(en == 1'b1, "R5 one stage", int'(en), 1);
        @(negedge clk);
        chk(en == 1'b1, "R5 two stages", int'(en), 1);
        @(negedge clk);
        chk(en == 1'b0, "R7 enable dropped", int'(en), 0);
        chk(abort == 1'b1, "R7 abort pulse", int'(abort), 1);
        @(negedge clk);
        chk(abort == 1'b0, "R7 abort one cycle", int'(abort), 0);
      end
    join
    col = 1'b0;
    settle();
    chk(abort_n == 1, "R7 abort count", abort_n, 1);
    chk(rx_n < 20, "R7 truncated", rx_n, 19);
    cmp_frame(rx_n, 77, "R7 prefix data");
    clr();
    push(3, 200, -1);
    settle();
    chk(rx_n == 3, "R7 next frame", rx_n, 3);
    cmp_frame(3, 200, "R7 next data");

    // R8 width change mid-frame deferred
    half = 1'b0; gig = 1'b1; mon_gig = 1'b1;
    clr();
    fork
      push(6, 5, -1);
      begin wait_en(); @(negedge clk); gig = 1'b0; end
    join
    settle();
    chk(en_cyc == 6, "R8 frame kept width", en_cyc, 6);
    cmp_frame(6, 5, "R8 data");
    mon_gig = 1'b0;
    clr();
    push(3, 61, -1);
    settle();
    chk(en_cyc == 6, "R8 next frame nibbles", en_cyc, 6);
    cmp_frame(3, 61, "R8 next data");

    // R9 stream underrun aborts
    gig = 1'b1; mon_gig = 1'b1;
    clr();
    push(8, 140, 3);
    settle();
    chk(rx_n == 3, "R9 bytes before gap", rx_n, 3);
    chk(abort_n == 1, "R9 abort", abort_n, 1);
    clr();
    push(2, 9, -1);
    settle();
    chk(rx_n == 2, "R9 recovery", rx_n, 2);

    finish_run();
  end
endmodule